// File: doc/BRIEF.md
# Bus Retry Limit Counter

This block watches one outstanding bus transaction and counts how many times the target answers it with a retry. When the count reaches a programmed limit, the block gives up on the transaction. It raises a one-cycle discard pulse for the protocol engine, sets a sticky expiration flag, and can also raise a system-error signal.

The limit is chosen by one-hot power-of-two select bits in a 32-bit control register. If no select bit is set, there is no limit. If more than one select bit is set, the smallest selected threshold applies. The system-error signal needs two enables: a suppress bit in the control register must be clear, and an error-enable input from the command register must be set. The protocol engine pulses a completion strobe whenever a transaction finishes, and that strobe restarts the count.

Top module: `retry_limit_guard`

## Requirements
- R1: After reset the control register reads 0x00000000, and `discard_pulse`, `serr_out`, `serr_stat_set` and `exp_flag` are all 0.
- R2: Only control bits 31, 24, 16, 8 (limit selects) and bit 0 (system-error suppress) hold written values. Every other bit reads 0 whatever is written.
- R3: The selects map to limits as follows: bit 8 gives 256 retries, bit 16 gives 65536, bit 24 gives 2^24 and bit 31 gives 2^31. `discard_pulse` rises on the retry that brings the count to the limit, never on an earlier one.
- R4: When several select bits are set, expiry happens at the smallest selected limit.
- R5: With all select bits zero, no number of retries causes an expiry. The count saturates instead of wrapping.
- R6: `discard_pulse` lasts exactly one cycle. The count restarts from zero at expiry, so the next expiry needs a full limit of further retries.
- R7: A `xact_done` strobe clears the count. A retry in the same cycle as `xact_done` is not counted.
- R8: Every expiry sets `exp_flag`, and the flag stays set afterwards.
- R9: `exp_flag_w1c` = 1 clears `exp_flag`. If an expiry happens in the same cycle, the flag stays set.
- R10: `serr_out` and `serr_stat_set` pulse together with `discard_pulse` only when control bit 0 was 0 and `cmd_serr_en` was 1 on the expiring retry.
- R11: When control bit 0 is 1, `serr_out` stays low on expiry, but the discard pulse and `exp_flag` still appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write data |
| ctl_rdata | output | 32 | Control register read data |
| retry_evt | input | 1 | One retry of the pending transaction |
| xact_done | input | 1 | Transaction finished; clears the count |
| cmd_serr_en | input | 1 | System-error enable from the command register |
| exp_flag_w1c | input | 1 | Write-one-to-clear strobe for the expiration flag |
| discard_pulse | output | 1 | One-cycle pulse: drop the pending transaction |
| serr_out | output | 1 | System-error assertion on expiry |
| serr_stat_set | output | 1 | Pulse that sets the signalled-system-error status bit |
| exp_flag | output | 1 | Sticky expiration flag |

## Verification
All results are registered. `discard_pulse`, `serr_out`, `serr_stat_set` and `exp_flag` change at the clock edge that samples the expiring retry. A control write appears on `ctl_rdata` right after its edge. The bench drives each stimulus at a falling edge, holds it across one rising edge, and then reads every output at the next falling edge, so each check looks at the cycle in which its result is due. Limit checks count the discard pulses seen over limit-minus-one retries, which must be none, and then require the pulse on the very next retry.

// File: rtl/retry_limit_pkg.sv
package retry_limit_pkg;
  localparam int CTL_W   = 32;
  localparam int SEL_N   = 4;
  localparam int SUPR_POS = 0;

  // select positions, ordered from largest to smallest threshold
  function automatic int sel_pos(input int idx);
    case (idx)
      0: sel_pos = 31;
      1: sel_pos = 24;
      2: sel_pos = 16;
      default: sel_pos = 8;
    endcase
  endfunction

  function automatic logic [CTL_W-1:0] sel_mask();
    logic [CTL_W-1:0] m;
    m = '0;
    for (int i = 0; i < SEL_N; i++) m[sel_pos(i)] = 1'b1;
    return m;
  endfunction

  function automatic logic [CTL_W-1:0] wr_mask();
    logic [CTL_W-1:0] m;
    m = sel_mask();
    m[SUPR_POS] = 1'b1;
    return m;
  endfunction

  // threshold = 2^(lowest set select position); 0 means unlimited
  function automatic logic [CTL_W:0] limit_of(input logic [CTL_W-1:0] ctl);
    logic [CTL_W:0] lim;
    lim = '0;
    for (int i = 0; i < SEL_N; i++)
      if (ctl[sel_pos(i)]) lim = (CTL_W+1)'(1) << sel_pos(i);
    return lim;
  endfunction
endpackage

// File: rtl/retry_ctl_reg.sv
module retry_ctl_reg
  import retry_limit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata
);
  localparam logic [CTL_W-1:0] MASK = wr_mask();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (we) rdata <= wdata & MASK;
  end
endmodule

// File: rtl/retry_counter.sv
module retry_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retry_evt,
  input  logic             clear,
  input  logic [CNT_W:0]   limit,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0] nxt;

  always_comb begin
    nxt    = {1'b0, cnt} + 1'b1;
    expire = retry_evt && !clear && (limit != '0) && (nxt == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (clear || expire)          cnt <= '0;
    else if (retry_evt && !(&cnt))     cnt <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/retry_status.sv
module retry_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic suppress,
  input  logic serr_en,
  input  logic w1c,
  output logic discard_pulse,
  output logic serr_out,
  output logic serr_stat_set,
  output logic exp_flag
);
  logic serr_ok;
  assign serr_ok = expire && !suppress && serr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      discard_pulse <= 1'b0;
      serr_out      <= 1'b0;
      serr_stat_set <= 1'b0;
      exp_flag      <= 1'b0;
    end else begin
      discard_pulse <= expire;
      serr_out      <= serr_ok;
      serr_stat_set <= serr_ok;
      if (expire)   exp_flag <= 1'b1;
      else if (w1c) exp_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/retry_limit_guard.sv
module retry_limit_guard
  import retry_limit_pkg::*;
#(
  parameter int CNT_W = CTL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             retry_evt,
  input  logic             xact_done,
  input  logic             cmd_serr_en,
  input  logic             exp_flag_w1c,
  output logic             discard_pulse,
  output logic             serr_out,
  output logic             serr_stat_set,
  output logic             exp_flag
);
  localparam int LIM_W = CNT_W + 1;

  logic [LIM_W-1:0] lim_val;
  logic             expire_evt;
  logic [CNT_W-1:0] ret_cnt;

  assign lim_val = LIM_W'(limit_of(ctl_rdata));

  retry_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata), .rdata(ctl_rdata)
  );

  retry_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .retry_evt(retry_evt), .clear(xact_done),
    .limit(lim_val), .expire(expire_evt), .cnt(ret_cnt)
  );

  retry_status u_st (
    .clk(clk), .rst_n(rst_n), .expire(expire_evt),
    .suppress(ctl_rdata[SUPR_POS]), .serr_en(cmd_serr_en), .w1c(exp_flag_w1c),
    .discard_pulse(discard_pulse), .serr_out(serr_out),
    .serr_stat_set(serr_stat_set), .exp_flag(exp_flag)
  );
endmodule

// File: rtl/retry_limit_guard_chk.sv
module retry_limit_guard_chk
  import retry_limit_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CTL_W-1:0] ctl_rdata,
  input logic             retry_evt,
  input logic             cmd_serr_en,
  input logic             exp_flag_w1c,
  input logic             expire_evt,
  input logic             discard_pulse,
  input logic             serr_out,
  input logic             exp_flag
);
  localparam logic [CTL_W-1:0] SELS = sel_mask();

  assert_single_discard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    discard_pulse |=> !discard_pulse);

  assert_expire_to_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> discard_pulse);

  assert_discard_needs_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    discard_pulse |-> $past(retry_evt));

  assert_no_limit_no_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    discard_pulse |-> (($past(ctl_rdata) & SELS) != '0));

  assert_flag_on_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard_pulse |-> exp_flag);

  assert_flag_clear_by_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(exp_flag) |-> $past(exp_flag_w1c));

  assert_serr_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    serr_out |-> (discard_pulse && $past(cmd_serr_en)));

  assert_serr_suppressed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    serr_out |-> !$past(ctl_rdata[SUPR_POS]));
endmodule

bind retry_limit_guard retry_limit_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_rdata(ctl_rdata), .retry_evt(retry_evt),
  .cmd_serr_en(cmd_serr_en), .exp_flag_w1c(exp_flag_w1c),
  .expire_evt(expire_evt), .discard_pulse(discard_pulse),
  .serr_out(serr_out), .exp_flag(exp_flag)
);

// File: tb/sim_retry_limit_guard.sv
`timescale 1ns/1ps
module sim_retry_limit_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        retry_evt = 1'b0, xact_done = 1'b0, cmd_serr_en = 1'b0, exp_flag_w1c = 1'b0;
  logic        discard_pulse, serr_out, serr_stat_set, exp_flag;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  retry_limit_guard u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .retry_evt(retry_evt), .xact_done(xact_done), .cmd_serr_en(cmd_serr_en),
    .exp_flag_w1c(exp_flag_w1c), .discard_pulse(discard_pulse), .serr_out(serr_out),
    .serr_stat_set(serr_stat_set), .exp_flag(exp_flag)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected threshold: smallest selected power of two, 0 = unlimited
  function automatic longint bench_limit(input logic [31:0] c);
    if (c[8])  return 64'd256;
    if (c[16]) return 64'd65536;
    if (c[24]) return 64'd1 << 24;
    if (c[31]) return 64'd1 << 31;
    return 0;
  endfunction

  task automatic wr_ctl(input logic [31:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic finish_xact();
    @(negedge clk); xact_done = 1'b1;
    @(negedge clk); xact_done = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); exp_flag_w1c = 1'b1;
    @(negedge clk); exp_flag_w1c = 1'b0;
  endtask

  task automatic retry_once(input logic w1c, input logic done,
                            output logic d, output logic s, output logic ss);
    @(negedge clk); retry_evt = 1'b1; exp_flag_w1c = w1c; xact_done = done;
    @(negedge clk); retry_evt = 1'b0; exp_flag_w1c = 1'b0; xact_done = 1'b0;
    d = discard_pulse; s = serr_out; ss = serr_stat_set;
  endtask

  task automatic retries(input longint n, output int nd);
    logic d, s, ss;
    nd = 0;
    for (longint i = 0; i < n; i++) begin
      retry_once(1'b0, 1'b0, d, s, ss);
      if (d) nd++;
    end
  endtask

  task automatic run_limit(input string req, input logic [31:0] cfg);
    int nd;
    logic d, s, ss;
    longint lim;
    lim = bench_limit(cfg);
    wr_ctl(cfg);
    finish_xact();
    clear_flag();
    retries(lim - 1, nd);
    check({req, " no early discard"}, nd, 0);
    check({req, " flag still clear"}, exp_flag, 0);
    retry_once(1'b0, 1'b0, d, s, ss);
    check({req, " discard at limit"}, d, 1);
    check({req, " flag set R8"}, exp_flag, 1);
  endtask

  initial begin
    #(5.0 * 199000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int nd;
    logic d, s, ss;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctl", ctl_rdata, 0);
    check("R1 discard", discard_pulse, 0);
    check("R1 serr", serr_out, 0);
    check("R1 sstat", serr_stat_set, 0);
    check("R1 flag", exp_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctl after release", ctl_rdata, 0);

    // R2 writable bits
    wr_ctl(32'hFFFF_FFFF);
    check("R2 all ones", ctl_rdata, 32'h8101_0101);
    wr_ctl(32'h7EFE_FEFE);
    check("R2 reserved only", ctl_rdata, 0);
    wr_ctl(32'h0);
    check("R2 zero", ctl_rdata, 0);

    cmd_serr_en = 1'b1;
    // R3 single select, R4 multiple selects
    run_limit("R3 bit8", 32'h0000_0100);
    run_limit("R4 bits31+16+8", 32'h8001_0100);
    run_limit("R4 bits24+16", 32'h0101_0000);

    // R5 unlimited
    wr_ctl(32'h0);
    finish_xact();
    retries(600, nd);
    check("R5 no expiry", nd, 0);

    // R6 pulse width and restart
    run_limit("R6 prep", 32'h0000_0100);
    @(negedge clk);
    check("R6 one-cycle pulse", discard_pulse, 0);
    retries(255, nd);
    check("R6 restart no early", nd, 0);
    retry_once(1'b0, 1'b0, d, s, ss);
    check("R6 restart discard", d, 1);

    // R7 clear by completion, concurrent retry ignored
    finish_xact();
    retries(255, nd);
    retry_once(1'b0, 1'b1, d, s, ss);
    check("R7 done+retry no discard", d, 0);
    retries(255, nd);
    check("R7 count cleared", nd, 0);
    retry_once(1'b0, 1'b0, d, s, ss);
    check("R7 discard after full limit", d, 1);

    // R10 / R11 enable sweep
    for (int k = 0; k < 4; k++) begin
      logic supr, en;
      supr = k[0]; en = k[1];
      wr_ctl({23'h0, 1'b1, 7'h0, supr});
      check("R2 suppress readback", ctl_rdata, {23'h0, 1'b1, 7'h0, supr});
      cmd_serr_en = en;
      finish_xact();
      clear_flag();
      retries(255, nd);
      retry_once(1'b0, 1'b0, d, s, ss);
      check("R11 discard regardless", d, 1);
      check("R10 serr gating", s, en && !supr);
      check("R10 serr status", ss, en && !supr);
      check("R11 flag regardless", exp_flag, 1);
    end

    // R9 write-one-to-clear and collision
    clear_flag();
    check("R9 cleared", exp_flag, 0);
    wr_ctl(32'h0000_0100);
    finish_xact();
    retries(255, nd);
    retry_once(1'b1, 1'b0, d, s, ss);
    check("R9 set wins", exp_flag, 1);
    clear_flag();
    check("R9 cleared again", exp_flag, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule